// File: doc/BRIEF.md
# Hibernation Wake Controller with Seconds Counter

This block lives in an always-on power domain. It runs from a fast crystal clock and keeps a seconds count that survives while the main supply is off. The clock is first divided by a prescaler, 128 by default, which turns a 4.194304 MHz crystal into a 32.768 kHz tick. A second divider of 32768 ticks then advances the 32-bit seconds counter.

Software reaches the block through a plain write-strobe and combinational-read register port. Through that port it loads the counter, sets an alarm value, clears the wake flags and asks to hibernate. Hibernation starts only on that request. While hibernated, the active-low hibernate output is held low so the main rail is switched off. The block returns to normal operation when the counter steps onto the alarm value, or when the active-low external wake pin has been seen low on two tick samples in a row. A small bank of scratch registers keeps its contents through hibernation.

Register addresses: 0 is the seconds counter (a write loads it), 1 is the alarm value, 2 is control, 3 is status, and 4 upward are the scratch words.

Top module: `hib_wake_ctl`

## Requirements
- R1: An internal tick fires once every PRESCALE clock cycles (default 128). A write to the seconds counter restarts the prescaler at phase zero.
- R2: The seconds counter at address 0 advances by one, wrapping at its full width, once every SEC_DIV ticks (default 32768). A write to address 0 loads the written value and restarts the second at phase zero. After a load, the counter therefore reads load + n/(PRESCALE*SEC_DIV), rounded down, n clocks later.
- R3: When the counter advances onto the value held at address 1, the alarm flag (status bit 1) is set. Writing control (address 2) with bit 1 set clears both wake flags.
- R4: The wake pin is synchronised by two flops and then sampled on each tick. The pin flag (status bit 2) is set only when two consecutive tick samples are both low. A low pulse shorter than one tick period leaves the flag clear.
- R5: Writing control with bit 0 set starts hibernation. The hibernate output goes low one clock after the write, and status bit 0 reads 1 while hibernated. No other event starts hibernation.
- R6: A hibernate request made while either wake flag is set is ignored, and the hibernate output stays high.
- R7: While hibernated, a set alarm flag or a set pin flag drives the hibernate output high again on the next clock.
- R8: After a wake, status bit 1 shows that the alarm caused it and status bit 2 shows that the pin caused it.
- R9: The seconds counter keeps counting while hibernated. Scratch words at addresses 4 upward keep their written values through hibernation and wake.
- R10: After reset, the hibernate output is high, and the counter, alarm value, status and scratch words all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for addr |
| wake_n | input | 1 | External wake pin, active low, idles high |
| hib_n | output | 1 | Hibernate output, low while hibernated |

## Verification
The assertion that links a rising alarm flag to the counter equalling the alarm value assumes software never rewrites the alarm in the same cycle that the counter advances. The bench writes the alarm only before it loads the counter, so that case never arises. The checks on hibernation entry assume control writes come only through the strobe port. The bench drives the wake pin only at falling clock edges and holds it for whole ticks, except for one deliberately short glitch. Counter loads are random, including a value next to the wrap point, and the expected reading is computed from the elapsed clock count.

// File: rtl/hib_pkg.sv
package hib_pkg;
   // fixed register addresses; scratch words start at A_SCR0
   localparam int A_SEC   = 0;
   localparam int A_MATCH = 1;
   localparam int A_CTRL  = 2;
   localparam int A_STAT  = 3;
   localparam int A_SCR0  = 4;
   // control bits
   localparam int C_HIB   = 0;
   localparam int C_CLR   = 1;
   // status bits
   localparam int S_HIB   = 0;
   localparam int S_ALARM = 1;
   localparam int S_PIN   = 2;
endpackage

// File: rtl/hib_tick_gen.sv
module hib_tick_gen #(
   parameter int PRESCALE = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   logic [PW-1:0] pre_q;

   assign tick = (pre_q == LAST);

   // R1: one tick per PRESCALE clocks, restartable by a counter load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pre_q <= '0;
      else if (restart)       pre_q <= '0;
      else if (tick)          pre_q <= '0;
      else                    pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/hib_rtc.sv
module hib_rtc #(
   parameter int CNT_W   = 32,
   parameter int SEC_DIV = 32768
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             match_wr,
   input  logic [CNT_W-1:0] wval,
   input  logic             clr,
   output logic [CNT_W-1:0] seconds,
   output logic [CNT_W-1:0] match_val,
   output logic             match_flag
);
   localparam int SW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
   localparam logic [SW-1:0] SLAST = SW'(SEC_DIV - 1);

   logic [SW-1:0]    sub_q;
   logic             step;
   logic [CNT_W-1:0] sec_nxt;

   assign step    = tick && (sub_q == SLAST) && !load;
   assign sec_nxt = seconds + 1'b1;

   // R2: sub-second phase and seconds count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         seconds <= '0;
      end else if (load) begin
         sub_q   <= '0;
         seconds <= wval;
      end else if (tick) begin
         sub_q <= (sub_q == SLAST) ? '0 : sub_q + 1'b1;
         if (step) seconds <= sec_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        match_val <= '0;
      else if (match_wr) match_val <= wval;
   end

   // R3: compare once per step, latch until cleared (set wins)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               match_flag <= 1'b0;
      else if (step && (sec_nxt == match_val))  match_flag <= 1'b1;
      else if (clr)                             match_flag <= 1'b0;
   end
endmodule

// File: rtl/hib_wake_filt.sv
module hib_wake_filt #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic wake_n,
   input  logic clr,
   output logic pin_flag
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   samp_q;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= wake_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], wake_n};
         end
      end
   endgenerate

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    samp_q <= 1'b1;
      else if (tick) samp_q <= synced;
   end

   // R4: two consecutive low tick samples raise the pin flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pin_flag <= 1'b0;
      else if (tick && !synced && !samp_q) pin_flag <= 1'b1;
      else if (clr)                        pin_flag <= 1'b0;
   end
endmodule

// File: rtl/hib_scratch.sv
module hib_scratch #(
   parameter int NREGS  = 4,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [NREGS];

   // R9: retained words, never touched by hibernation
   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (wr_en && (int'(idx) == i))  mem[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREGS; i++)
         if (int'(idx) == i) rdata = mem[i];
   end
endmodule

// File: rtl/hib_wake_ctl.sv
module hib_wake_ctl
   import hib_pkg::*;
#(
   parameter int PRESCALE    = 128,
   parameter int SEC_DIV     = 32768,
   parameter int CNT_W       = 32,
   parameter int NREGS       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   input  logic              wake_n,
   output logic              hib_n
);
   localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

   generate
      if (PRESCALE < 2)               begin : g_bad_pre  $error("PRESCALE must be at least 2"); end
      if (SEC_DIV < 2)                begin : g_bad_div  $error("SEC_DIV must be at least 2"); end
      if (CNT_W < 3)                  begin : g_bad_w    $error("CNT_W must be at least 3"); end
      if (NREGS < 1)                  begin : g_bad_n    $error("NREGS must be at least 1"); end
      if (SYNC_STAGES < 1)            begin : g_bad_s    $error("SYNC_STAGES must be at least 1"); end
      if ((1 << ADDR_W) < A_SCR0 + NREGS) begin : g_bad_a $error("ADDR_W too small for map"); end
   endgenerate

   logic             tick;
   logic             sec_load, match_wr, wr_ctrl, wr_scr, is_scr;
   logic             clr, req, pending;
   logic             match_flag, pin_flag, hib_q;
   logic [CNT_W-1:0] seconds, match_val, scr_rdata;
   logic [IDX_W-1:0] scr_idx;

   assign is_scr   = (int'(addr) >= A_SCR0) && (int'(addr) < A_SCR0 + NREGS);
   assign scr_idx  = IDX_W'(int'(addr) - A_SCR0);
   assign sec_load = wr_en && (int'(addr) == A_SEC);
   assign match_wr = wr_en && (int'(addr) == A_MATCH);
   assign wr_ctrl  = wr_en && (int'(addr) == A_CTRL);
   assign wr_scr   = wr_en && is_scr;
   assign clr      = wr_ctrl && wdata[C_CLR];
   assign req      = wr_ctrl && wdata[C_HIB];
   assign pending  = match_flag || pin_flag;

   hib_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(sec_load), .tick(tick)
   );

   hib_rtc #(.CNT_W(CNT_W), .SEC_DIV(SEC_DIV)) u_rtc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(sec_load),
      .match_wr(match_wr), .wval(wdata), .clr(clr),
      .seconds(seconds), .match_val(match_val), .match_flag(match_flag)
   );

   hib_wake_filt #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wake_n(wake_n),
      .clr(clr), .pin_flag(pin_flag)
   );

   hib_scratch #(.NREGS(NREGS), .DATA_W(CNT_W), .IDX_W(IDX_W)) u_scr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_scr), .idx(scr_idx),
      .wdata(wdata), .rdata(scr_rdata)
   );

   // R5 R6 R7: software entry, blocked while pending, exit on any flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hib_q <= 1'b0;
      else if (hib_q && pending)    hib_q <= 1'b0;
      else if (!hib_q && req && !pending) hib_q <= 1'b1;
   end

   assign hib_n = !hib_q;

   // R8: status bits name the wake source
   always_comb begin
      rdata = '0;
      if (is_scr) rdata = scr_rdata;
      else begin
         case (int'(addr))
            A_SEC:   rdata = seconds;
            A_MATCH: rdata = match_val;
            A_STAT: begin
               rdata[S_HIB]   = hib_q;
               rdata[S_ALARM] = match_flag;
               rdata[S_PIN]   = pin_flag;
            end
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/hib_wake_ctl_chk.sv
module hib_wake_ctl_chk #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hib_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic              pending,
   input logic              tick,
   input logic              sec_load,
   input logic              match_flag,
   input logic [CNT_W-1:0]  seconds,
   input logic [CNT_W-1:0]  match_val
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(hib_pkg::A_CTRL);

   p_entry_by_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hib_n) |-> $past(wr_en && addr == CTRL_A && wdata[hib_pkg::C_HIB]));

   p_blocked_when_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hib_n && pending) |=> hib_n);

   p_exit_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hib_n) |-> $past(pending));

   p_wake_leaves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hib_n && pending) |=> hib_n);

   p_sec_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_load && !tick) |=> $stable(seconds));

   p_alarm_on_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> (seconds == match_val));
endmodule

bind hib_wake_ctl hib_wake_ctl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hib_n(hib_n), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .pending(pending), .tick(tick), .sec_load(sec_load),
   .match_flag(match_flag), .seconds(seconds), .match_val(match_val)
);

// File: tb/test_hib_wake_ctl.sv
module test_hib_wake_ctl;
   localparam int P  = 4;
   localparam int S  = 4;
   localparam int N  = 4;
   localparam int W  = 32;
   localparam int AW = 3;
   localparam int SECP = P * S;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rdata;
   logic          wake_n = 1'b1;
   logic          hib_n;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;
   logic [W-1:0] scr_model [N];

   hib_wake_ctl #(.PRESCALE(P), .SEC_DIV(S), .CNT_W(W), .NREGS(N),
                  .SYNC_STAGES(2), .ADDR_W(AW)) i_hib_wake_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .wake_n(wake_n), .hib_n(hib_n)
   );

   always #10 clk = ~clk;

   function automatic logic [W-1:0] exp_sec(logic [W-1:0] ld, int n);
      return ld + W'(n / SECP);
   endfunction

   function automatic logic [W-1:0] stat(bit hib, bit alarm, bit pin);
      return W'({pin, alarm, hib});
   endfunction

   task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(int a, logic [W-1:0] d);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [W-1:0] d);
      addr = AW'(a); #1; d = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, ld;
      int n;
      void'($urandom(32'h1234_5678));
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 hib_n", W'(hib_n), W'(1));
      rd(0, v); check("R10 seconds", v, 0);
      rd(1, v); check("R10 alarm", v, 0);
      rd(3, v); check("R10 status", v, 0);
      for (int i = 0; i < N; i++) begin
         rd(4 + i, v); check("R10 scratch", v, 0);
         scr_model[i] = '0;
      end

      // R9 random scratch traffic
      for (int k = 0; k < 20; k++) begin
         int i;
         i = $urandom_range(N - 1);
         v = $urandom;
         wr(4 + i, v);
         scr_model[i] = v;
         i = $urandom_range(N - 1);
         rd(4 + i, v); check("R9 scratch rw", v, scr_model[i]);
      end

      // R1 R2 random loads and elapsed counts, one near wrap
      for (int k = 0; k < 8; k++) begin
         ld = (k == 0) ? 32'hFFFF_FFFF : W'($urandom);
         n  = $urandom_range(60);
         wr(0, ld);
         idle(n);
         rd(0, v); check("R1 R2 seconds count", v, exp_sec(ld, n));
      end

      // R3 alarm exactly at the second step
      wr(1, 12);
      wr(0, 10);
      wr(2, 32'h2);             // clear, n = 1
      idle(30);                 // n = 31
      rd(3, v); check("R3 alarm not yet", v, stat(0, 0, 0));
      idle(1);                  // n = 32
      rd(3, v); check("R3 alarm set", v, stat(0, 1, 0));
      wr(2, 32'h2);
      rd(3, v); check("R3 alarm cleared", v, stat(0, 0, 0));

      // R4 short glitch ignored
      wake_n = 1'b0; idle(2); wake_n = 1'b1; idle(12);
      rd(3, v); check("R4 glitch ignored", v, stat(0, 0, 0));

      // R5 enter hibernation
      wr(2, 32'h1);
      check("R5 hib_n low", W'(hib_n), W'(0));
      rd(3, v); check("R5 status hib", v, stat(1, 0, 0));
      idle(10);
      check("R5 stays hibernated", W'(hib_n), W'(0));

      // R7 R8 wake via pin
      wake_n = 1'b0; idle(24); wake_n = 1'b1;
      check("R7 pin wake", W'(hib_n), W'(1));
      rd(3, v); check("R8 pin source", v, stat(0, 0, 1));

      // R6 request ignored while pending
      idle(8);
      wr(2, 32'h1);
      check("R6 ignored hib_n", W'(hib_n), W'(1));
      rd(3, v); check("R6 status", v, stat(0, 0, 1));

      // R7 R8 R9 wake via alarm, counter runs while hibernated
      wr(2, 32'h2);
      wr(2, 32'h1);
      check("R5 hib again", W'(hib_n), W'(0));
      wr(1, 101);
      wr(0, 100);
      idle(20);
      check("R7 alarm wake", W'(hib_n), W'(1));
      rd(3, v); check("R8 alarm source", v, stat(0, 1, 0));
      rd(0, v); check("R9 counted during hib", v, exp_sec(100, 20));
      for (int i = 0; i < N; i++) begin
         rd(4 + i, v); check("R9 scratch retained", v, scr_model[i]);
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule